// File: doc/BRIEF.md
# Overlay Visibility Controller

This block decides whether an expansion card's 8 KB ROM and 8 KB RAM replace the host CPU's own memory in the lowest 16 KB of the address space. Software pages the card in and out by writing to one of two I/O ports. The block turns each memory access into a card ROM select, a card RAM select, and an inhibit line that keeps the host's internal memory from answering.

A press of the stop button pages the card in and raises a one-cycle NMI request, so the card's freeze code takes over. When that code finally returns to the interrupted program through the return address, the block hides the card. From then on it ignores the paging ports and the stop button until the next system reset.

Every input is sampled on the rising clock edge. Each cycle that has `io_wr` high counts as one I/O write, and each cycle that has `mem_rd` high counts as one memory read. The selects and the inhibit line are combinational from the current access.

Top module: `ovl_vis_ctrl`

## Requirements
- R1: After reset the overlay is off. `rom_cs`, `ram_cs`, `host_inhibit` and `nmi_req` are all low, and the card is visible.
- R2: An I/O write to address 0xFEE8 turns the overlay on. The port matches only when the address equals 1111_1110_1110_10x0 in binary. Address bit 1 = 0 means enable. Any other address, including 0xFEE9, has no effect, and the block has no data input.
- R3: An I/O write to address 0xFEEA (bit 1 = 1) turns the overlay off.
- R4: While the overlay is on, a memory read in 0x0000–0x1FFF asserts `rom_cs`. A memory write in that range never asserts `rom_cs`.
- R5: While the overlay is on, a memory read or write in 0x2000–0x3FFF asserts `ram_cs`.
- R6: While the overlay is on, any memory access in 0x0000–0x3FFF asserts `host_inhibit`. Accesses at 0x4000 and above assert nothing. While the overlay is off, no access asserts any select.
- R7: A rising edge of `stop_btn` turns the overlay on, enters the post-stop state, and gives exactly one single-cycle `nmi_req` pulse, however long the button is held.
- R8: In the post-stop state with the overlay on, an opcode fetch (`m1` and `mem_rd`) from 0x0064 or 0x0065 is still served from card ROM in that cycle. From the next cycle on, the overlay is off and the card is hidden.
- R9: A hidden card ignores both paging ports and the stop button: no select and no `nmi_req`.
- R10: An opcode fetch from 0x0065 outside the post-stop state does not hide the card. A plain data read of 0x0065 in the post-stop state does not hide it either.
- R11: A system reset returns a hidden card to the visible state, so the paging ports work again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| addr | input | 16 | CPU address bus |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| m1 | input | 1 | Current read is an opcode fetch |
| stop_btn | input | 1 | Stop button, asynchronous, active high |
| rom_cs | output | 1 | Card ROM select |
| ram_cs | output | 1 | Card RAM select |
| host_inhibit | output | 1 | Blocks host internal ROM/RAM |
| nmi_req | output | 1 | Single-cycle NMI request |

## Verification
The paging ports are tried with the exact enable and disable addresses and with a neighbour that differs only in bit 0. This shows that the full decode is used and not only bit 1.

The address map is tried with reads and writes on both sides of 0x2000 and 0x4000, which shows ROM, RAM and untouched regions apart. The return address is fetched in three contexts: as an opcode after a stop, as a data read after a stop, and as an opcode without a stop. Only the first hides the card. The stop button is held for many cycles, both while visible and while hidden, so that one pulse can be told apart from repeated pulses and from no pulse.

// File: rtl/ovl_pkg.sv
// Shared types for the overlay visibility controller.
package ovl_pkg;
    // Visibility life cycle: open after reset, frozen after stop, hidden after return.
    typedef enum logic [1:0] {
        VIS_OPEN   = 2'd0,
        VIS_FROZEN = 2'd1,
        VIS_HIDDEN = 2'd2
    } vis_state_t;
endpackage

// File: rtl/ovl_stop_sync.sv
// Synchronises the asynchronous stop button and emits a one-cycle pulse on
// each rising edge. Assumes the button is already debounced externally.
module ovl_stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn,
    output logic pulse
);
    logic [STAGES:0] shreg;

    // Shift the button through the synchroniser plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[STAGES-1:0], btn};
    end

    // Rising edge seen at the synchroniser output.
    assign pulse = shreg[STAGES-1] & ~shreg[STAGES];
endmodule

// File: rtl/ovl_port_dec.sv
// Decodes the enable/disable I/O port pair and the return-address opcode
// fetch. Assumes PORT_BASE has bit 1 clear and RET_ADDR has bit 0 clear.
module ovl_port_dec #(
    parameter int             AW        = 16,
    parameter logic [AW-1:0]  PORT_BASE = 16'hFEE8,
    parameter logic [AW-1:0]  RET_ADDR  = 16'h0064
) (
    input  logic [AW-1:0] addr,
    input  logic          io_wr,
    input  logic          mem_rd,
    input  logic          m1,
    output logic          en_hit,
    output logic          dis_hit,
    output logic          ret_fetch
);
    localparam logic [AW-1:0] SEL_MASK = ~AW'(2);

    logic port_hit;

    // Match every address bit except bit 1, which selects enable or disable.
    always_comb begin
        port_hit  = io_wr && ((addr & SEL_MASK) == (PORT_BASE & SEL_MASK));
        en_hit    = port_hit && !addr[1];
        dis_hit   = port_hit &&  addr[1];
        ret_fetch = m1 && mem_rd && (addr[AW-1:1] == RET_ADDR[AW-1:1]);
    end
endmodule

// File: rtl/ovl_vis_fsm.sv
// Holds the overlay-on flag and the visibility state. Stop takes priority
// over port writes; a hidden card stays hidden until reset.
module ovl_vis_fsm
    import ovl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_pulse,
    input  logic       en_hit,
    input  logic       dis_hit,
    input  logic       ret_fetch,
    output vis_state_t state,
    output logic       paged,
    output logic       nmi_req
);
    // Advance visibility state, overlay flag and NMI pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= VIS_OPEN;
            paged   <= 1'b0;
            nmi_req <= 1'b0;
        end else begin
            nmi_req <= 1'b0;
            case (state)
                VIS_OPEN: begin
                    if (stop_pulse) begin
                        paged   <= 1'b1;
                        nmi_req <= 1'b1;
                        state   <= VIS_FROZEN;
                    end else if (en_hit) begin
                        paged <= 1'b1;
                    end else if (dis_hit) begin
                        paged <= 1'b0;
                    end
                end
                VIS_FROZEN: begin
                    if (stop_pulse) begin
                        paged   <= 1'b1;
                        nmi_req <= 1'b1;
                    end else if (ret_fetch && paged) begin
                        paged <= 1'b0;
                        state <= VIS_HIDDEN;
                    end else if (en_hit) begin
                        paged <= 1'b1;
                    end else if (dis_hit) begin
                        paged <= 1'b0;
                    end
                end
                VIS_HIDDEN: begin
                    paged <= 1'b0;
                end
                default: begin
                    state <= VIS_OPEN;
                    paged <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/ovl_map.sv
// Maps the current memory access onto card ROM, card RAM and host inhibit.
// Assumes ROM and RAM are equal-sized banks stacked from address zero.
module ovl_map #(
    parameter int AW     = 16,
    parameter int BANK_AW = 13
) (
    input  logic [AW-1:0] addr,
    input  logic          mem_rd,
    input  logic          mem_wr,
    input  logic          paged,
    output logic          rom_cs,
    output logic          ram_cs,
    output logic          host_inhibit
);
    logic in_overlay;
    logic ram_bank;
    logic any_acc;

    // Combinational select generation for the low overlay window.
    always_comb begin
        in_overlay   = (addr[AW-1:BANK_AW+1] == '0);
        ram_bank     = addr[BANK_AW];
        any_acc      = mem_rd || mem_wr;
        rom_cs       = paged && mem_rd  && in_overlay && !ram_bank;
        ram_cs       = paged && any_acc && in_overlay &&  ram_bank;
        host_inhibit = paged && any_acc && in_overlay;
    end
endmodule

// File: rtl/ovl_vis_ctrl.sv
// Top of the overlay visibility controller: port decode, stop edge detect,
// visibility state machine and address map. All inputs sampled on clk.
module ovl_vis_ctrl
    import ovl_pkg::*;
#(
    parameter int            AW          = 16,
    parameter int            BANK_AW     = 13,
    parameter int            SYNC_STAGES = 2,
    parameter logic [AW-1:0] PORT_BASE   = 16'hFEE8,
    parameter logic [AW-1:0] RET_ADDR    = 16'h0064
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          io_wr,
    input  logic          mem_rd,
    input  logic          mem_wr,
    input  logic          m1,
    input  logic          stop_btn,
    output logic          rom_cs,
    output logic          ram_cs,
    output logic          host_inhibit,
    output logic          nmi_req
);
    logic       stop_pulse;
    logic       en_hit;
    logic       dis_hit;
    logic       ret_fetch;
    logic       paged;
    vis_state_t vis_state;

    ovl_stop_sync #(.STAGES(SYNC_STAGES)) u_stop (
        .clk(clk), .rst_n(rst_n), .btn(stop_btn), .pulse(stop_pulse)
    );

    ovl_port_dec #(.AW(AW), .PORT_BASE(PORT_BASE), .RET_ADDR(RET_ADDR)) u_dec (
        .addr(addr), .io_wr(io_wr), .mem_rd(mem_rd), .m1(m1),
        .en_hit(en_hit), .dis_hit(dis_hit), .ret_fetch(ret_fetch)
    );

    ovl_vis_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .stop_pulse(stop_pulse),
        .en_hit(en_hit), .dis_hit(dis_hit), .ret_fetch(ret_fetch),
        .state(vis_state), .paged(paged), .nmi_req(nmi_req)
    );

    ovl_map #(.AW(AW), .BANK_AW(BANK_AW)) u_map (
        .addr(addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .paged(paged),
        .rom_cs(rom_cs), .ram_cs(ram_cs), .host_inhibit(host_inhibit)
    );
endmodule

// File: rtl/ovl_vis_chk.sv
// Assertion checker for ovl_vis_ctrl, attached by bind below.
module ovl_vis_chk
    import ovl_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic        io_wr,
    input logic        mem_rd,
    input logic        m1,
    input vis_state_t  state,
    input logic        paged,
    input logic        stop_pulse,
    input logic        nmi_req,
    input logic        rom_cs,
    input logic        ram_cs,
    input logic        host_inhibit
);
    // R7: the NMI request never lasts two cycles.
    p_nmi_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    // R7: an NMI request always comes with the overlay on.
    p_nmi_pages_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> paged);

    // R2: the enable port turns the overlay on in a visible card.
    p_port_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && addr == 16'hFEE8 && state != VIS_HIDDEN && !stop_pulse) |=> paged);

    // R8: a return fetch served from ROM in the post-stop state hides the card.
    p_ret_hides_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m1 && mem_rd && addr == 16'h0065 && rom_cs && state == VIS_FROZEN && !stop_pulse)
        |=> (state == VIS_HIDDEN && !paged));

    // R9: hidden is sticky until reset.
    p_hidden_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == VIS_HIDDEN |=> state == VIS_HIDDEN);

    // R9: a hidden card drives no select and no NMI.
    p_hidden_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
        state == VIS_HIDDEN |-> !(rom_cs || ram_cs || host_inhibit || nmi_req));

    // R6: a card select always blocks host memory.
    p_sel_inhibit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_cs || ram_cs) |-> host_inhibit);
endmodule

bind ovl_vis_ctrl ovl_vis_chk u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .io_wr(io_wr), .mem_rd(mem_rd),
    .m1(m1), .state(vis_state), .paged(paged), .stop_pulse(stop_pulse),
    .nmi_req(nmi_req), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .host_inhibit(host_inhibit)
);

// File: tb/ovl_vis_ctrl_test.sv
// Directed bench for ovl_vis_ctrl: one task per scenario.
module ovl_vis_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        io_wr = 1'b0;
    logic        mem_rd = 1'b0;
    logic        mem_wr = 1'b0;
    logic        m1 = 1'b0;
    logic        stop_btn = 1'b0;
    logic        rom_cs, ram_cs, host_inhibit, nmi_req;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovl_vis_ctrl uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .io_wr(io_wr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .m1(m1), .stop_btn(stop_btn), .rom_cs(rom_cs),
        .ram_cs(ram_cs), .host_inhibit(host_inhibit), .nmi_req(nmi_req)
    );

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply reset for a few cycles.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One I/O write cycle.
    task automatic io_write(input logic [15:0] a);
        @(negedge clk);
        addr = a; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; addr = 16'h8000;
    endtask

    // Probe one access; returns {rom,ram,inhibit} as a 3-bit code.
    task automatic probe(input logic [15:0] a, input logic rd, input logic wr,
                         input logic op, output int code);
        @(negedge clk);
        addr = a; mem_rd = rd; mem_wr = wr; m1 = op;
        #1;
        code = {rom_cs, ram_cs, host_inhibit};
        @(negedge clk);
        mem_rd = 1'b0; mem_wr = 1'b0; m1 = 1'b0; addr = 16'h8000;
    endtask

    // Hold stop for many cycles and count NMI pulses.
    task automatic press_stop(output int pulses);
        pulses = 0;
        @(negedge clk);
        stop_btn = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (nmi_req) pulses++;
        end
        stop_btn = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (nmi_req) pulses++;
        end
    endtask

    task automatic t_reset();
        int c;
        do_reset();
        #1;
        chk("R1 nmi", int'(nmi_req), 0);
        probe(16'h0010, 1, 0, 0, c);
        chk("R1 overlay off", c, 0);
    endtask

    task automatic t_ports();
        int c;
        io_write(16'hFEE9);
        probe(16'h0010, 1, 0, 0, c);
        chk("R2 FEE9 ignored", c, 0);
        io_write(16'hFEE8);
        probe(16'h0010, 1, 0, 0, c);
        chk("R2 enable", c, 3'b101);
        io_write(16'hFEEA);
        probe(16'h0010, 1, 0, 0, c);
        chk("R3 disable", c, 0);
        probe(16'h2000, 1, 0, 0, c);
        chk("R6 off no ram", c, 0);
    endtask

    task automatic t_map();
        int c;
        io_write(16'hFEE8);
        probe(16'h1FFF, 1, 0, 0, c);
        chk("R4 rom top", c, 3'b101);
        probe(16'h0066, 0, 1, 0, c);
        chk("R4 rom write", c, 3'b001);
        probe(16'h2000, 1, 0, 0, c);
        chk("R5 ram read", c, 3'b011);
        probe(16'h3FFF, 0, 1, 0, c);
        chk("R5 ram write", c, 3'b011);
        probe(16'h4000, 1, 0, 0, c);
        chk("R6 above window", c, 0);
        probe(16'h1000, 0, 0, 0, c);
        chk("R6 idle", c, 0);
        io_write(16'hFEEA);
    endtask

    task automatic t_no_hide();
        int c;
        io_write(16'hFEE8);
        probe(16'h0065, 1, 0, 1, c);
        chk("R10 call without stop", c, 3'b101);
        probe(16'h0100, 1, 0, 0, c);
        chk("R10 still paged", c, 3'b101);
        io_write(16'hFEEA);
    endtask

    task automatic t_freeze_return();
        int c, p;
        press_stop(p);
        chk("R7 one nmi", p, 1);
        probe(16'h0066, 1, 0, 1, c);
        chk("R7 paged by stop", c, 3'b101);
        probe(16'h0065, 1, 0, 0, c);
        chk("R10 data read no hide", c, 3'b101);
        probe(16'h0065, 1, 0, 1, c);
        chk("R8 fetch served", c, 3'b101);
        probe(16'h0100, 1, 0, 0, c);
        chk("R8 hidden after", c, 0);
    endtask

    task automatic t_hidden();
        int c, p;
        io_write(16'hFEE8);
        probe(16'h0010, 1, 0, 0, c);
        chk("R9 port ignored", c, 0);
        press_stop(p);
        chk("R9 stop no nmi", p, 0);
        probe(16'h2000, 0, 1, 0, c);
        chk("R9 stop no page", c, 0);
    endtask

    task automatic t_reset_unhide();
        int c;
        do_reset();
        io_write(16'hFEE8);
        probe(16'h0010, 1, 0, 0, c);
        chk("R11 visible again", c, 3'b101);
    endtask

    initial begin
        addr = 16'h8000;
        t_reset();
        t_ports();
        t_map();
        t_no_hide();
        t_freeze_return();
        t_hidden();
        t_reset_unhide();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule